// File: doc/BRIEF.md
# Modulo Timer with Overflow Flag

This block is a 16-bit timer counter run by a small register file on a simple bus. The bus is synchronous: a write commits on the clock edge where `bus_wr_i` is high, and `bus_rdata_o` follows the selected address at once. Reads take effect on the clock edge where `bus_rd_i` is high. The counter advances on prescaled ticks and turns at a programmable modulo value. In the default mode it wraps to zero. In the up/down mode it reverses and counts back down.

Each turn at the modulo value sets a sticky overflow flag. Software clears the flag with a two-step handshake: first a read that sees the flag set, then a write of zero to it. A new overflow that lands inside the handshake cancels the clear, so no overflow can be lost. An interrupt request output follows the flag, gated by an enable bit.

The tick source is one of three: the bus clock, a fixed-rate enable input, or an external clock that is synchronised and edge-detected. After the source comes a power-of-two prescaler.

The bus has four addresses:
- Address 0 is the status/control register.
- Address 1 is the modulo register.
- Address 2 is the counter. Reading it returns the count, and writing it clears the count.
- Address 3 reads as zero.

The interface has no valid/ready handshake, because it carries no data stream. Every pin is a plain control or status signal.

Top module: `mod_timer`

## Requirements
- R1: After reset the control register reads 0x00, the modulo register and the counter read 0, and `irq_o` is 0.
- R2: The control register at address 0 holds these fields: overflow flag in bit 7, interrupt enable in bit 6, up/down select in bit 5, clock source in bits 4:3, and prescale code in bits 2:0. Bits 6:0 read back exactly as written.
- R3: With up/down select 0, each tick advances the count by one. A tick at the modulo value returns the count to 0. A modulo of 0 makes the counter run over the full 16-bit range.
- R4: The overflow flag becomes 1 on the clock edge where the counter turns at the modulo value.
- R5: The flag clears only when a write of bit 7 = 0 to address 0 follows a read of address 0 that saw the flag at 1. A zero write without that earlier read leaves the flag set.
- R6: Writing 1 to bit 7 never sets the flag.
- R7: If an overflow occurs after the arming read and before the clearing write, the clear is cancelled and the flag stays 1.
- R8: `irq_o` is 1 exactly when both the flag and the interrupt enable are 1.
- R9: Clock source code 00 stops the counter.
- R10: Prescale code p divides the selected tick rate by 2^p. The new code applies from the cycle after the write.
- R11: Clock source code 01 ticks every bus clock. Code 10 ticks once per cycle in which `fixed_tick_i` is high. Code 11 ticks once per rising edge of `ext_clk_i`, which first passes a two-flop synchroniser.
- R12: With up/down select 1, the count runs 0 up to the modulo value, then back down to 0, and repeats. The flag is set at the reversal at the top.
- R13: A write to address 2 clears the counter, the prescaler and the count direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_addr_i | input | 2 | Register address |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe, used to arm the flag clear |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data for the selected address |
| fixed_tick_i | input | 1 | Fixed-rate tick enable, one bus cycle wide |
| ext_clk_i | input | 1 | Asynchronous external clock |
| irq_o | output | 1 | Overflow interrupt request |

## Verification
On every cycle, the assertions check four things:
- the flag rises after each overflow event and falls only after an armed zero write;
- the stopped source produces no ticks;
- the count holds when no tick arrives;
- an up-mode tick at the top wraps the count to zero.

The directed scenarios cover what needs a whole sequence to show: the exact up-mode and up/down count patterns, the prescale rate, the fixed and external sources, the order of the clear handshake, and the cancellation by a mid-sequence overflow.

// File: rtl/mod_timer_pkg.sv
package mod_timer_pkg;
  localparam int CNT_W = 16;
  localparam int PS_W  = 3;

  typedef enum logic [1:0] {
    SRC_OFF   = 2'b00,
    SRC_BUS   = 2'b01,
    SRC_FIXED = 2'b10,
    SRC_EXT   = 2'b11
  } clk_src_e;

  typedef struct packed {
    logic            flag;
    logic            irq_en;
    logic            updown;
    clk_src_e        src;
    logic [PS_W-1:0] ps;
  } ctrl_t;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_MOD  = 2'd1;
  localparam logic [1:0] ADDR_CNT  = 2'd2;
endpackage

// File: rtl/tmr_clk_select.sv
module tmr_clk_select
  import mod_timer_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  clk_src_e src_i,
  input  logic     fixed_tick_i,
  input  logic     ext_clk_i,
  output logic     tick_o
);
  localparam int SH_W = SYNC_STAGES + 1;
  logic [SH_W-1:0] sync_q;
  logic ext_rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[SH_W-2:0], ext_clk_i};
  end

  assign ext_rise = sync_q[SH_W-2] & ~sync_q[SH_W-1];

  always_comb begin
    unique case (src_i)
      SRC_OFF:   tick_o = 1'b0;
      SRC_BUS:   tick_o = 1'b1;
      SRC_FIXED: tick_o = fixed_tick_i;
      SRC_EXT:   tick_o = ext_rise;
      default:   tick_o = 1'b0;
    endcase
  end

  assert_src_off_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_i == SRC_OFF) |-> !tick_o);
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int PS_W = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic [PS_W-1:0] ps_i,
  input  logic            tick_i,
  output logic            tick_o
);
  localparam int DIV_W = (1 << PS_W) - 1;
  logic [DIV_W-1:0] div_q, mask;

  always_comb begin
    for (int i = 0; i < DIV_W; i++) mask[i] = (i < int'(ps_i));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     div_q <= '0;
    else if (clr_i)  div_q <= '0;
    else if (tick_i) div_q <= div_q + 1'b1;
  end

  assign tick_o = tick_i && ((div_q & mask) == mask);

  assert_out_needs_in_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> tick_i);
endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             tick_i,
  input  logic             updown_i,
  input  logic [CNT_W-1:0] modulo_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o
);
  logic [CNT_W-1:0] cnt_q, top;
  logic down_q;

  assign top   = (modulo_i == '0) ? '1 : modulo_i;
  assign ovf_o = tick_i && !clr_i && !down_q && (cnt_q == top);
  assign cnt_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      down_q <= 1'b0;
    end else if (clr_i) begin
      cnt_q  <= '0;
      down_q <= 1'b0;
    end else begin
      if (!updown_i) down_q <= 1'b0;
      if (tick_i) begin
        if (!updown_i) begin
          cnt_q <= (cnt_q == top) ? '0 : cnt_q + 1'b1;
        end else if (!down_q) begin
          if (cnt_q == top) begin
            cnt_q  <= cnt_q - 1'b1;
            down_q <= 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end else if (cnt_q == '0) begin
          cnt_q  <= cnt_q + 1'b1;
          down_q <= 1'b0;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  assert_hold_no_tick_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !clr_i) |=> $stable(cnt_q));
  assert_up_wrap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !clr_i && !updown_i && cnt_q == top) |=> (cnt_q == '0));
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
  import mod_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       addr_i,
  input  logic             wr_i,
  input  logic             rd_i,
  input  logic [15:0]      wdata_i,
  input  logic             ovf_i,
  output ctrl_t            ctrl_o,
  output logic [CNT_W-1:0] modulo_o
);
  ctrl_t ctrl_q;
  logic armed_q, wr_ctrl, clr_ok;

  assign wr_ctrl = wr_i && (addr_i == ADDR_CTRL);
  assign clr_ok  = wr_ctrl && armed_q && !wdata_i[7];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= '0;
      armed_q  <= 1'b0;
      modulo_o <= '0;
    end else begin
      if (wr_ctrl) begin
        ctrl_q.irq_en <= wdata_i[6];
        ctrl_q.updown <= wdata_i[5];
        ctrl_q.src    <= clk_src_e'(wdata_i[4:3]);
        ctrl_q.ps     <= wdata_i[2:0];
      end
      if (ovf_i)       ctrl_q.flag <= 1'b1;
      else if (clr_ok) ctrl_q.flag <= 1'b0;

      if (ovf_i || wr_ctrl) armed_q <= 1'b0;
      else if (rd_i && addr_i == ADDR_CTRL && ctrl_q.flag) armed_q <= 1'b1;

      if (wr_i && addr_i == ADDR_MOD) modulo_o <= wdata_i[CNT_W-1:0];
    end
  end

  assign ctrl_o = ctrl_q;

  assert_flag_on_ovf_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_i |=> ctrl_q.flag);
  assert_flag_fall_armed_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ctrl_q.flag) |-> $past(wr_ctrl && armed_q && !wdata_i[7] && !ovf_i));
endmodule

// File: rtl/mod_timer.sv
module mod_timer
  import mod_timer_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [1:0]  bus_addr_i,
  input  logic        bus_wr_i,
  input  logic        bus_rd_i,
  input  logic [15:0] bus_wdata_i,
  output logic [15:0] bus_rdata_o,
  input  logic        fixed_tick_i,
  input  logic        ext_clk_i,
  output logic        irq_o
);
  ctrl_t ctrl;
  logic [CNT_W-1:0] modulo, cnt;
  logic src_tick, pre_tick, ovf, cnt_clr;

  assign cnt_clr = bus_wr_i && (bus_addr_i == ADDR_CNT);

  tmr_regs #(.CNT_W(CNT_W)) regs_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(bus_addr_i), .wr_i(bus_wr_i),
    .rd_i(bus_rd_i), .wdata_i(bus_wdata_i), .ovf_i(ovf),
    .ctrl_o(ctrl), .modulo_o(modulo));

  tmr_clk_select #(.SYNC_STAGES(2)) csel_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .src_i(ctrl.src),
    .fixed_tick_i(fixed_tick_i), .ext_clk_i(ext_clk_i), .tick_o(src_tick));

  tmr_prescaler #(.PS_W(PS_W)) pre_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(cnt_clr), .ps_i(ctrl.ps),
    .tick_i(src_tick), .tick_o(pre_tick));

  tmr_count_core #(.CNT_W(CNT_W)) core_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(cnt_clr), .tick_i(pre_tick),
    .updown_i(ctrl.updown), .modulo_i(modulo), .cnt_o(cnt), .ovf_o(ovf));

  always_comb begin
    unique case (bus_addr_i)
      ADDR_CTRL: bus_rdata_o = {8'h00, ctrl};
      ADDR_MOD:  bus_rdata_o = 16'(modulo);
      ADDR_CNT:  bus_rdata_o = 16'(cnt);
      default:   bus_rdata_o = '0;
    endcase
  end

  assign irq_o = ctrl.flag & ctrl.irq_en;
endmodule

// File: tb/mod_timer_tb.sv
module mod_timer_tb_top;
  logic clk = 0, rst_n = 0;
  logic [1:0] addr = 0;
  logic wr = 0, rd = 0, fix = 0, ext = 0;
  logic [15:0] wdata = 0, rdata;
  logic irq;
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  mod_timer dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(addr), .bus_wr_i(wr), .bus_rd_i(rd),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .fixed_tick_i(fix),
    .ext_clk_i(ext), .irq_o(irq));

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1;
    @(negedge clk); wr = 0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk); addr = a; rd = 1; #1 d = rdata;
    @(negedge clk); rd = 0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [15:0] d);
    addr = a; #1 d = rdata;
  endtask

  task automatic clear_flag();
    logic [15:0] d;
    bus_wr(0, 16'h0000);
    bus_rd(0, d);
    bus_wr(0, 16'h0000);
  endtask

  task automatic t_reset();
    logic [15:0] d;
    peek(0, d); check("R1 ctrl", d, 0);
    peek(1, d); check("R1 modulo", d, 0);
    peek(2, d); check("R1 count", d, 0);
    check("R1 irq", irq, 0);
  endtask

  task automatic t_layout();
    logic [15:0] d;
    bus_wr(0, 16'h007F);
    peek(0, d); check("R2 readback", d, 16'h7F);
    bus_wr(0, 16'h0000);
  endtask

  task automatic t_up_wrap();
    logic [15:0] d;
    bus_wr(2, 0);
    bus_wr(1, 16'd4);
    bus_wr(0, 16'h0008);
    for (int k = 1; k <= 14; k++) begin
      @(negedge clk);
      peek(2, d); check("R3 up count", d, k % 5);
      peek(0, d); check("R4 flag", d[7], (k >= 5) ? 1 : 0);
    end
    bus_wr(0, 16'h0000);
    peek(2, d);
    begin
      logic [15:0] held = d;
      repeat (10) @(negedge clk);
      peek(2, d); check("R9 stopped", d, held);
    end
  endtask

  task automatic t_clear();
    logic [15:0] d;
    peek(0, d); check("R5 flag before", d[7], 1);
    bus_wr(0, 16'h0000);
    peek(0, d); check("R5 unarmed write keeps flag", d[7], 1);
    bus_rd(0, d);
    bus_wr(0, 16'h0000);
    peek(0, d); check("R5 armed clear", d[7], 0);
    bus_wr(0, 16'h0080);
    peek(0, d); check("R6 write one", d[7], 0);
  endtask

  task automatic t_cancel();
    logic [15:0] d;
    bus_wr(1, 16'd3);
    bus_wr(0, 16'h0008);
    repeat (6) @(negedge clk);
    bus_rd(0, d); check("R7 flag set", d[7], 1);
    repeat (6) @(negedge clk);
    bus_wr(0, 16'h0000);
    peek(0, d); check("R7 cancelled clear", d[7], 1);
  endtask

  task automatic t_irq();
    logic [15:0] d;
    check("R8 irq masked", irq, 0);
    bus_wr(0, 16'h0040);
    check("R8 irq on", irq, 1);
    bus_rd(0, d);
    bus_wr(0, 16'h0040);
    check("R8 irq off after clear", irq, 0);
    bus_wr(0, 16'h0000);
  endtask

  task automatic t_prescale();
    logic [15:0] d;
    bus_wr(1, 0);
    bus_wr(2, 0);
    peek(2, d); check("R13 counter clear", d, 0);
    bus_wr(0, 16'h000A);
    repeat (40) @(negedge clk);
    peek(2, d); check("R10 divide by 4", d, 10);
    bus_wr(0, 16'h0000);
    bus_wr(2, 0);
    bus_wr(0, 16'h000F);
    repeat (256) @(negedge clk);
    peek(2, d); check("R10 divide by 128", d, 2);
    bus_wr(0, 16'h0000);
  endtask

  task automatic t_sources();
    logic [15:0] d;
    bus_wr(2, 0);
    bus_wr(0, 16'h0010);
    repeat (5) @(negedge clk);
    peek(2, d); check("R11 fixed idle", d, 0);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); fix = 1;
      @(negedge clk); fix = 0;
      @(negedge clk);
    end
    peek(2, d); check("R11 fixed ticks", d, 5);
    bus_wr(2, 0);
    bus_wr(0, 16'h0018);
    for (int i = 0; i < 6; i++) begin
      ext = 1; repeat (3) @(negedge clk);
      ext = 0; repeat (3) @(negedge clk);
    end
    repeat (5) @(negedge clk);
    peek(2, d); check("R11 external edges", d, 6);
    bus_wr(0, 16'h0000);
  endtask

  task automatic t_updown();
    logic [15:0] d;
    clear_flag();
    bus_wr(2, 0);
    bus_wr(1, 16'd3);
    bus_wr(0, 16'h0028);
    for (int k = 1; k <= 13; k++) begin
      int m;
      m = k % 6;
      @(negedge clk);
      peek(2, d); check("R12 up/down count", d, (m <= 3) ? m : 6 - m);
      peek(0, d); check("R12 flag at top", d[7], (k >= 4) ? 1 : 0);
    end
    bus_wr(0, 16'h0000);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 t_reset();
    rst_n = 1;
    t_reset();
    t_layout();
    t_up_wrap();
    t_clear();
    t_cancel();
    bus_wr(0, 16'h0000);
    t_irq();
    t_prescale();
    t_sources();
    t_updown();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule